// File: doc/BRIEF.md
# Round-Robin Ring Scheduler

This block schedules work in a strict round-robin rotation. There is no central pointer. The scheduler is a ring of identical four-state cells. Each cell raises a one-cycle start pulse and later a one-cycle finish pulse. Control passes from a cell to the next one in the ring only through a two-way handshake between the two neighbours.

Every cell has its own advance-enable input. A cell can act only in a cycle where its enable is high, so the environment decides how long each cell stays in each state. A handshake needs both partners to be enabled in the same cycle. The two cells then change state together.

Cells are numbered 0 to N_CELLS-1. The successor of cell i is cell (i+1) mod N_CELLS. Cell 0 holds the start right after reset.

Top module: `rr_ring_sched`

## Requirements
- R1: While reset is low and just after it is released, cell 0 is in ISSUE and every other cell is in WAIT. The per-cell state codes are ISSUE=0, PASS=1, CLOSE=2 and WAIT=3, and cell i sits at `state_o[2i+1:2i]`.
- R2: A cell whose advance-enable is low keeps its state across the clock edge and drives neither of its pulses.
- R3: A cell in ISSUE with its enable high drives its bit of `start_o` high in that cycle and is in PASS after the edge.
- R4: A cell in CLOSE with its enable high drives its bit of `finish_o` high in that cycle and is in WAIT after the edge.
- R5: A cell in PASS moves to CLOSE, and at the same edge its successor moves from WAIT to ISSUE, exactly when the successor is in WAIT and both enables are high. Otherwise both cells hold their states.
- R6: Start pulses follow strict ring order. At most one cell starts per cycle, the first start after reset comes from cell 0, and every later start comes from the successor of the previous starter.
- R7: For each cell, start and finish pulses alternate, and the first pulse after reset is a start.
- R8: In every cycle exactly one cell is in ISSUE or PASS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv_en | input | N_CELLS | Per-cell advance-enable |
| start_o | output | N_CELLS | Per-cell start pulse |
| finish_o | output | N_CELLS | Per-cell finish pulse |
| state_o | output | 2*N_CELLS | Packed per-cell state codes |

## Verification
The bench builds the ring with N_CELLS=3. This is the smallest ring in which a cell's predecessor and successor are different cells, so a single cell can be held in CLOSE by its own enable while the token moves on past it.

With three cells, a short table reaches every state pairing between neighbours, including a handshake blocked because the successor is still in CLOSE. A few hundred cycles of pseudo-random enables then complete many full rotations of the ring. During those cycles the bench checks rotation order, per-cell alternation and the single-token invariant.

// File: rtl/rr_ring_pkg.sv
package rr_ring_pkg;

  typedef enum logic [1:0] {
    ST_ISSUE = 2'd0,
    ST_PASS  = 2'd1,
    ST_CLOSE = 2'd2,
    ST_WAIT  = 2'd3
  } cell_st_e;

  localparam int unsigned ST_BITS = 2;

  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned n);
    return (idx + 1) % n;
  endfunction

  function automatic int unsigned ring_prev(input int unsigned idx, input int unsigned n);
    return (idx + n - 1) % n;
  endfunction

endpackage

// File: rtl/rr_link.sv
module rr_link (
  input  logic up_offer,
  input  logic up_en,
  input  logic dn_ready,
  input  logic dn_en,
  output logic go
);

  always_comb begin
    go = up_offer && dn_ready && up_en && dn_en;
  end

endmodule

// File: rtl/rr_cell.sv
module rr_cell
  import rr_ring_pkg::*;
#(
  parameter bit IS_HEAD = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv_en,
  input  logic       give_go,
  input  logic       take_go,
  output logic [1:0] state_o,
  output logic       start_o,
  output logic       finish_o,
  output logic       offer_o,
  output logic       ready_o
);

  localparam cell_st_e RST_ST = IS_HEAD ? ST_ISSUE : ST_WAIT;

  cell_st_e st_q;
  cell_st_e st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_ISSUE: if (adv_en)  st_d = ST_PASS;
      ST_PASS:  if (give_go) st_d = ST_CLOSE;
      ST_CLOSE: if (adv_en)  st_d = ST_WAIT;
      ST_WAIT:  if (take_go) st_d = ST_ISSUE;
      default:               st_d = RST_ST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= RST_ST;
    else        st_q <= st_d;
  end

  always_comb begin
    start_o  = (st_q == ST_ISSUE) && adv_en;
    finish_o = (st_q == ST_CLOSE) && adv_en;
    offer_o  = (st_q == ST_PASS);
    ready_o  = (st_q == ST_WAIT);
    state_o  = st_q;
  end

endmodule

// File: rtl/rr_ring_sched.sv
module rr_ring_sched
  import rr_ring_pkg::*;
#(
  parameter int unsigned N_CELLS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_CELLS-1:0]           adv_en,
  output logic [N_CELLS-1:0]           start_o,
  output logic [N_CELLS-1:0]           finish_o,
  output logic [ST_BITS*N_CELLS-1:0]   state_o
);

  logic [N_CELLS-1:0] offer;
  logic [N_CELLS-1:0] ready;
  logic [N_CELLS-1:0] hs_go;

  for (genvar i = 0; i < N_CELLS; i++) begin : g_ring
    localparam int unsigned NXT = ring_next(i, N_CELLS);
    localparam int unsigned PRV = ring_prev(i, N_CELLS);

    rr_cell #(.IS_HEAD(i == 0)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv_en   (adv_en[i]),
      .give_go  (hs_go[i]),
      .take_go  (hs_go[PRV]),
      .state_o  (state_o[ST_BITS*i +: ST_BITS]),
      .start_o  (start_o[i]),
      .finish_o (finish_o[i]),
      .offer_o  (offer[i]),
      .ready_o  (ready[i])
    );

    rr_link u_link (
      .up_offer (offer[i]),
      .up_en    (adv_en[i]),
      .dn_ready (ready[NXT]),
      .dn_en    (adv_en[NXT]),
      .go       (hs_go[i])
    );
  end

endmodule

// File: rtl/rr_ring_sched_chk.sv
module rr_ring_sched_chk
  import rr_ring_pkg::*;
#(
  parameter int unsigned N_CELLS = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [N_CELLS-1:0]         adv_en,
  input logic [N_CELLS-1:0]         start_o,
  input logic [N_CELLS-1:0]         finish_o,
  input logic [ST_BITS*N_CELLS-1:0] state_o,
  input logic [N_CELLS-1:0]         hs_go
);

  logic [N_CELLS-1:0] last_start;
  logic [N_CELLS-1:0] want_start;
  logic [N_CELLS-1:0] phase;
  logic [N_CELLS-1:0] tok;

  always_comb begin
    want_start = {last_start[N_CELLS-2:0], last_start[N_CELLS-1]};
    for (int k = 0; k < N_CELLS; k++) begin
      tok[k] = (state_o[ST_BITS*k +: ST_BITS] == ST_ISSUE) ||
               (state_o[ST_BITS*k +: ST_BITS] == ST_PASS);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_start <= {1'b1, {(N_CELLS-1){1'b0}}};
      phase      <= '0;
    end else begin
      if (|start_o) last_start <= start_o;
      phase <= phase ^ start_o ^ finish_o;
    end
  end

  // R6
  one_starter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_o));

  // R6
  rotation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|start_o) |-> (start_o == want_start));

  // R8
  single_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tok) == 1);

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    localparam int unsigned NXT = ring_next(i, N_CELLS);

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_en[i] |=> $stable(state_o[ST_BITS*i +: ST_BITS]));

    // R2
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_en[i] |-> (!start_o[i] && !finish_o[i]));

    // R3
    start_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_o[i] |=> (state_o[ST_BITS*i +: ST_BITS] == ST_PASS));

    // R4
    finish_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      finish_o[i] |=> (state_o[ST_BITS*i +: ST_BITS] == ST_WAIT));

    // R5
    handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hs_go[i] |=> ((state_o[ST_BITS*i +: ST_BITS] == ST_CLOSE) &&
                    (state_o[ST_BITS*NXT +: ST_BITS] == ST_ISSUE)));

    // R5
    pass_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_o[ST_BITS*i +: ST_BITS] == ST_PASS) && !hs_go[i]) |=>
        (state_o[ST_BITS*i +: ST_BITS] == ST_PASS));

    // R7
    start_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_o[i] |-> !phase[i]);

    // R7
    finish_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      finish_o[i] |-> phase[i]);
  end

endmodule

bind rr_ring_sched rr_ring_sched_chk #(.N_CELLS(N_CELLS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .adv_en   (adv_en),
  .start_o  (start_o),
  .finish_o (finish_o),
  .state_o  (state_o),
  .hs_go    (hs_go)
);

// File: tb/rr_ring_sched_test.sv
module rr_ring_sched_test;

  localparam int unsigned N = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] adv_en = '0;
  logic [N-1:0] start_o;
  logic [N-1:0] finish_o;
  logic [2*N-1:0] state_o;

  int applied = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  rr_ring_sched #(.N_CELLS(N)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_en   (adv_en),
    .start_o  (start_o),
    .finish_o (finish_o),
    .state_o  (state_o)
  );

  // {enable, expected start, expected finish, expected state after edge}
  // state codes: ISSUE=0 PASS=1 CLOSE=2 WAIT=3, packed {c2,c1,c0}
  localparam logic [14:0] VEC [13] = '{
    {3'b000, 3'b000, 3'b000, 6'b11_11_00},
    {3'b001, 3'b001, 3'b000, 6'b11_11_01},
    {3'b001, 3'b000, 3'b000, 6'b11_11_01},
    {3'b010, 3'b000, 3'b000, 6'b11_11_01},
    {3'b011, 3'b000, 3'b000, 6'b11_00_10},
    {3'b111, 3'b010, 3'b001, 6'b11_01_11},
    {3'b110, 3'b000, 3'b000, 6'b00_10_11},
    {3'b100, 3'b100, 3'b000, 6'b01_10_11},
    {3'b101, 3'b000, 3'b000, 6'b10_10_00},
    {3'b001, 3'b001, 3'b000, 6'b10_10_01},
    {3'b011, 3'b000, 3'b010, 6'b10_11_01},
    {3'b011, 3'b000, 3'b000, 6'b10_00_10},
    {3'b111, 3'b010, 3'b101, 6'b11_01_11}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    applied++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n  = 1'b0;
    adv_en = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(state_o == 6'b11_11_00, "R1 state in reset", state_o, 6'b11_11_00);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 after release
    check(state_o == 6'b11_11_00, "R1 state after release", state_o, 6'b11_11_00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired (all requirements) actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] exp_start;
    logic [N-1:0] phase;
    logic [7:0]   lf;
    int           tokens;
    int           n_starts;
    logic [1:0]   s;

    do_reset();

    // table walk: R2 R3 R4 R5
    for (int v = 0; v < 13; v++) begin
      adv_en = VEC[v][14:12];
      #1;
      check(start_o == VEC[v][11:9], $sformatf("R3 start pulse vec %0d", v),
            start_o, VEC[v][11:9]);
      check(finish_o == VEC[v][8:6], $sformatf("R4 finish pulse vec %0d", v),
            finish_o, VEC[v][8:6]);
      @(posedge clk);
      #1;
      check(state_o == VEC[v][5:0], $sformatf("R2/R5 state vec %0d", v),
            state_o, VEC[v][5:0]);
      @(negedge clk);
    end

    // directed R2: long stall from a mid-rotation state
    adv_en = '0;
    for (int c = 0; c < 6; c++) begin
      #1;
      check(start_o == '0 && finish_o == '0, "R2 no pulse while stalled",
            {start_o, finish_o}, 0);
      @(negedge clk);
      check(state_o == 6'b11_01_11, "R2 state held", state_o, 6'b11_01_11);
    end

    // directed R5: successor enabled but predecessor not -> no handoff
    adv_en = 3'b100;
    @(negedge clk);
    check(state_o == 6'b11_01_11, "R5 one-sided enable no handoff", state_o, 6'b11_01_11);

    // random enables: R6 R7 R8
    do_reset();
    exp_start = 3'b001;
    phase     = '0;
    lf        = 8'hA5;
    n_starts  = 0;
    for (int c = 0; c < 400; c++) begin
      lf     = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      adv_en = lf[2:0] | ((c % 4 == 0) ? 3'b111 : 3'b000);
      #1;
      tokens = 0;
      for (int k = 0; k < N; k++) begin
        s = state_o[2*k +: 2];
        if (s == 2'd0 || s == 2'd1) tokens++;
      end
      check(tokens == 1, "R8 single token", tokens, 1);
      if (start_o != '0) begin
        check(start_o == exp_start, "R6 start order", start_o, exp_start);
        exp_start = {exp_start[N-2:0], exp_start[N-1]};
        n_starts++;
      end
      for (int k = 0; k < N; k++) begin
        if (start_o[k]) begin
          check(!phase[k], $sformatf("R7 start alternation cell %0d", k), phase[k], 0);
          phase[k] = 1'b1;
        end
        if (finish_o[k]) begin
          check(phase[k], $sformatf("R7 finish alternation cell %0d", k), phase[k], 1);
          phase[k] = 1'b0;
        end
      end
      @(negedge clk);
    end
    check(n_starts > 20, "R6 rotation progress", n_starts, 21);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end

endmodule